// File: doc/BRIEF.md
# Multi-Phase Current Balancing Adjuster

This block evens out current sharing between two to four power stages that are driven from a single compensator. Each stage carries its own adjustment value. The stage's pulse-width ramp threshold is the common threshold from the compensator plus that adjustment. Whenever a fresh set of per-stage current readings is flagged valid, the block picks the stage drawing the most current and the stage drawing the least. It then moves a bounded step of adjustment from the first to the second. This shortens the busy stage's pulses and lengthens the idle stage's pulses by the same amount, so the sum of all adjustments does not change.

Adjustments are unsigned and start at mid-scale, so a stage can give up adjustment without going below zero. A deadband on the current spread stops the loop from dithering once the stages are close. The number of active stages is a run-time input, and stages above that count take no part in the search.

Top module: `phase_balance`

## Requirements
- R1: A synchronous reset sets every stage's adjustment to the mid-scale value 2^(ADJ_W-1) (512 by default). After reset, every threshold output reads base_thr + 512.
- R2: Each threshold output equals base_thr plus that stage's adjustment. If the sum exceeds 2^THR_W-1 (4095 by default), the output saturates at that value and does not wrap. Threshold outputs follow base_thr with no clock delay.
- R3: On a transfer, the lowest-current stage's adjustment rises by exactly the amount that the highest-current stage's adjustment falls, so the sum of all adjustments is unchanged.
- R4: The highest stage is the one with the largest current among stages 0 to n_eff-1, and the lowest stage is the one with the smallest. On ties, the lowest stage index wins. Stage i's current is cur_in[i*CUR_W +: CUR_W].
- R5: The amount moved is the smallest of three values: step, the high stage's current adjustment, and 2^ADJ_W-1 minus the low stage's adjustment. No adjustment ever goes below 0 or above 2^ADJ_W-1.
- R6: The active count is n_eff = min(n_active, N_STAGES). With n_eff below 2, no adjustment changes. Adjustments of stages at index n_eff or above never change.
- R7: When the highest and lowest stage are the same stage, as happens when all active currents are equal, no adjustment changes.
- R8: No transfer takes place when the highest current minus the lowest current is smaller than deadband. A transfer does take place when the difference equals or exceeds deadband.
- R9: Adjustments change only at the clock edge that samples cur_valid high. With cur_valid low, every adjustment holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_valid | input | 1 | Marks cur_in as a new measurement set |
| cur_in | input | N_STAGES*CUR_W | Per-stage currents; stage i at bits [i*CUR_W +: CUR_W] |
| base_thr | input | THR_W | Common ramp threshold from the compensator |
| n_active | input | $clog2(N_STAGES+1) | Number of stages tied to the rail |
| step | input | STEP_W | Largest adjustment moved per update |
| deadband | input | CUR_W | Minimum current spread that triggers a transfer |
| thr_out | output | N_STAGES*THR_W | Per-stage adjusted thresholds; stage i at bits [i*THR_W +: THR_W] |

## Verification
The assertions assume two things about the inputs. Reset must be held for at least one clock edge before operation, which gives the sum-conservation check a defined starting sum. The current, step and threshold inputs must be driven to known values on every edge. The bench meets both conditions: it drives every input from time zero, holds reset for two edges, and changes inputs only on the falling edge. The random stimulus draws n_active over its full code range, including values above the stage count. Step sizes go up to the full range, so the clamps on the amount moved are reached. Deadband is drawn small, and current values are sometimes narrowed to a few codes so that ties and sub-deadband spreads occur often.

// File: rtl/cbal_pkg.sv
package cbal_pkg;

   function automatic int unsigned cbal_umin(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/cbal_extrema.sv
module cbal_extrema #(
   parameter int N     = 4,
   parameter int CUR_W = 12,
   parameter int IDX_W = 2,
   parameter int NA_W  = 3
) (
   input  logic [N-1:0][CUR_W-1:0] cur,
   input  logic [NA_W-1:0]         n_eff,
   output logic [IDX_W-1:0]        hi_idx,
   output logic [IDX_W-1:0]        lo_idx,
   output logic [CUR_W-1:0]        spread
);

   always_comb begin
      hi_idx = '0;
      lo_idx = '0;
      for (int i = 1; i < N; i++) begin
         if (NA_W'(i) < n_eff) begin
            if (cur[i] > cur[hi_idx]) hi_idx = IDX_W'(i);
            if (cur[i] < cur[lo_idx]) lo_idx = IDX_W'(i);
         end
      end
      spread = cur[hi_idx] - cur[lo_idx];
   end

endmodule

// File: rtl/cbal_adj_bank.sv
module cbal_adj_bank #(
   parameter int N      = 4,
   parameter int ADJ_W  = 10,
   parameter int STEP_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    xfer_en,
   input  logic [IDX_W-1:0]        hi_idx,
   input  logic [IDX_W-1:0]        lo_idx,
   input  logic [STEP_W-1:0]       step,
   output logic [N-1:0][ADJ_W-1:0] adj_q
);
   import cbal_pkg::*;

   localparam logic [ADJ_W-1:0] ADJ_MID = ADJ_W'(1) << (ADJ_W - 1);
   localparam logic [ADJ_W-1:0] ADJ_MAX = '1;
   localparam int               SUM_W   = ADJ_W + $clog2(N) + 1;

   logic [ADJ_W-1:0] amt;
   logic [SUM_W-1:0] adj_sum;

   always_comb begin
      int unsigned a;
      a   = cbal_umin(int'(step), int'(adj_q[hi_idx]));
      a   = cbal_umin(a, int'(ADJ_MAX - adj_q[lo_idx]));
      amt = ADJ_W'(a);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < N; i++) adj_q[i] <= ADJ_MID;
      end else if (xfer_en) begin
         adj_q[hi_idx] <= adj_q[hi_idx] - amt;
         adj_q[lo_idx] <= adj_q[lo_idx] + amt;
      end
   end

   always_comb begin
      adj_sum = '0;
      for (int i = 0; i < N; i++) adj_sum = adj_sum + SUM_W'(adj_q[i]);
   end

   // R3
   sum_const_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (adj_sum == $past(adj_sum)));

   // R9 (also covers the hold cases of R6, R7, R8)
   hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !xfer_en |=> $stable(adj_q));

endmodule

// File: rtl/cbal_thr_sat.sv
module cbal_thr_sat #(
   parameter int THR_W = 12,
   parameter int ADJ_W = 10
) (
   input  logic [THR_W-1:0] base,
   input  logic [ADJ_W-1:0] adj,
   output logic [THR_W-1:0] thr
);

   logic [THR_W:0] wide;

   always_comb begin
      wide = {1'b0, base} + (THR_W + 1)'(adj);
      thr  = wide[THR_W] ? '1 : wide[THR_W-1:0];
   end

endmodule

// File: rtl/phase_balance.sv
module phase_balance #(
   parameter int N_STAGES = 4,
   parameter int CUR_W    = 12,
   parameter int THR_W    = 12,
   parameter int ADJ_W    = 10,
   parameter int STEP_W   = 8
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         cur_valid,
   input  logic [N_STAGES*CUR_W-1:0]    cur_in,
   input  logic [THR_W-1:0]             base_thr,
   input  logic [$clog2(N_STAGES+1)-1:0] n_active,
   input  logic [STEP_W-1:0]            step,
   input  logic [CUR_W-1:0]             deadband,
   output logic [N_STAGES*THR_W-1:0]    thr_out
);

   localparam int NA_W  = $clog2(N_STAGES + 1);
   localparam int IDX_W = $clog2(N_STAGES);

   if (N_STAGES < 2 || N_STAGES > 16) begin : g_bad_stages
      $error("phase_balance: N_STAGES must lie in 2..16");
   end
   if (ADJ_W > THR_W) begin : g_bad_adj
      $error("phase_balance: ADJ_W may not exceed THR_W");
   end
   if (STEP_W > ADJ_W) begin : g_bad_step
      $error("phase_balance: STEP_W may not exceed ADJ_W");
   end

   logic [N_STAGES-1:0][CUR_W-1:0] cur_a;
   logic [N_STAGES-1:0][ADJ_W-1:0] adj_a;
   logic [N_STAGES-1:0][THR_W-1:0] thr_a;
   logic [NA_W-1:0]                n_eff;
   logic                           multi;
   logic [IDX_W-1:0]               hi_idx, lo_idx;
   logic [CUR_W-1:0]               spread;
   logic                           xfer_en;

   assign n_eff   = (n_active > NA_W'(N_STAGES)) ? NA_W'(N_STAGES) : n_active;
   assign multi   = (n_eff >= NA_W'(2));
   assign xfer_en = cur_valid && multi && (hi_idx != lo_idx) && (spread >= deadband);

   cbal_extrema #(
      .N(N_STAGES), .CUR_W(CUR_W), .IDX_W(IDX_W), .NA_W(NA_W)
   ) u_extrema (
      .cur(cur_a), .n_eff(n_eff), .hi_idx(hi_idx), .lo_idx(lo_idx), .spread(spread)
   );

   cbal_adj_bank #(
      .N(N_STAGES), .ADJ_W(ADJ_W), .STEP_W(STEP_W), .IDX_W(IDX_W)
   ) u_bank (
      .clk(clk), .rst(rst), .xfer_en(xfer_en), .hi_idx(hi_idx), .lo_idx(lo_idx),
      .step(step), .adj_q(adj_a)
   );

   for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
      assign cur_a[g] = cur_in[g*CUR_W +: CUR_W];

      cbal_thr_sat #(.THR_W(THR_W), .ADJ_W(ADJ_W)) u_sat (
         .base(base_thr), .adj(adj_a[g]), .thr(thr_a[g])
      );

      assign thr_out[g*THR_W +: THR_W] = thr_a[g];

      // R2
      thr_floor_chk: assert property (@(posedge clk) disable iff (rst)
         1'b1 |-> (thr_a[g] >= base_thr));
   end

   // R4
   pick_active_chk: assert property (@(posedge clk) disable iff (rst)
      multi |-> ((NA_W'(hi_idx) < n_eff) && (NA_W'(lo_idx) < n_eff)));

   // R4
   pick_order_chk: assert property (@(posedge clk) disable iff (rst)
      multi |-> (cur_a[hi_idx] >= cur_a[lo_idx]));

endmodule

// File: tb/tb_phase_balance.sv
module tb_phase_balance;
   localparam int CLK_PERIOD = 10;
   localparam int NS     = 4;
   localparam int CW     = 12;
   localparam int TW     = 12;
   localparam int AW     = 10;
   localparam int SW     = 8;
   localparam int NAW    = 3;
   localparam int AMID   = 512;
   localparam int AMAX   = 1023;
   localparam int TMAX   = 4095;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 cur_valid = 1'b0;
   logic [NS*CW-1:0]     cur_in = '0;
   logic [TW-1:0]        base_thr = '0;
   logic [NAW-1:0]       n_active = '0;
   logic [SW-1:0]        step = '0;
   logic [CW-1:0]        deadband = '0;
   logic [NS*TW-1:0]     thr_out;

   int checks = 0;
   int fails  = 0;
   int adj_m [NS];

   always #(CLK_PERIOD/2) clk = ~clk;

   phase_balance dut (
      .clk(clk), .rst(rst), .cur_valid(cur_valid), .cur_in(cur_in),
      .base_thr(base_thr), .n_active(n_active), .step(step),
      .deadband(deadband), .thr_out(thr_out)
   );

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_thr(input int s);
      int v = int'(base_thr) + adj_m[s];
      return (v > TMAX) ? TMAX : v;
   endfunction

   function automatic int cur_of(input int s);
      return int'(cur_in[s*CW +: CW]);
   endfunction

   task automatic model_update();
      int ne, hi, lo, amt;
      if (!cur_valid) return;
      ne = (int'(n_active) > NS) ? NS : int'(n_active);
      if (ne < 2) return;
      hi = 0; lo = 0;
      for (int i = 1; i < ne; i++) begin
         if (cur_of(i) > cur_of(hi)) hi = i;
         if (cur_of(i) < cur_of(lo)) lo = i;
      end
      if (hi == lo) return;
      if (cur_of(hi) - cur_of(lo) < int'(deadband)) return;
      amt = int'(step);
      if (adj_m[hi] < amt) amt = adj_m[hi];
      if (AMAX - adj_m[lo] < amt) amt = AMAX - adj_m[lo];
      adj_m[hi] -= amt;
      adj_m[lo] += amt;
   endtask

   task automatic check_all(input string req);
      for (int s = 0; s < NS; s++) check_eq(req, int'(thr_out[s*TW +: TW]), exp_thr(s));
   endtask

   task automatic apply(input logic v, input int c0, input int c1, input int c2, input int c3,
                        input int n, input int st, input int db, input int base, input string req);
      @(negedge clk);
      cur_valid = v;
      cur_in    = {CW'(c3), CW'(c2), CW'(c1), CW'(c0)};
      n_active  = NAW'(n);
      step      = SW'(st);
      deadband  = CW'(db);
      base_thr  = TW'(base);
      model_update();
      @(posedge clk);
      #(CLK_PERIOD/4);
      check_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd2718);
      for (int s = 0; s < NS; s++) adj_m[s] = AMID;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      base_thr = TW'(100);
      #1;
      // R1 reset state
      for (int s = 0; s < NS; s++) check_eq("R1", int'(thr_out[s*TW +: TW]), 612);

      // R3 basic two-stage transfer
      apply(1, 500, 100, 0, 0, 2, 10, 0, 100, "R3");
      check_eq("R3", int'(thr_out[0 +: TW]), 602);
      check_eq("R3", int'(thr_out[TW +: TW]), 622);
      check_eq("R6", int'(thr_out[2*TW +: TW]), 612);

      // R9 valid low holds
      apply(0, 900, 0, 0, 0, 4, 50, 0, 100, "R9");
      check_eq("R9", int'(thr_out[0 +: TW]), 602);

      // R7 all equal: no change
      apply(1, 300, 300, 300, 300, 4, 50, 0, 100, "R7");
      check_eq("R7", int'(thr_out[3*TW +: TW]), 612);

      // R4 ties: stage 0 high, stage 2 low
      apply(1, 200, 200, 50, 50, 4, 5, 0, 100, "R4");
      check_eq("R4", int'(thr_out[0 +: TW]), 597);
      check_eq("R4", int'(thr_out[2*TW +: TW]), 617);
      check_eq("R4", int'(thr_out[3*TW +: TW]), 612);

      // R8 deadband: spread 5 < 6 holds, spread 5 >= 5 moves
      apply(1, 105, 100, 0, 0, 2, 3, 6, 100, "R8");
      check_eq("R8", int'(thr_out[TW +: TW]), 622);
      apply(1, 105, 100, 0, 0, 2, 3, 5, 100, "R8");
      check_eq("R8", int'(thr_out[TW +: TW]), 625);

      // R6 single and zero stages, and oversize count
      apply(1, 900, 0, 0, 0, 1, 50, 0, 100, "R6");
      apply(1, 900, 0, 0, 0, 0, 50, 0, 100, "R6");
      check_eq("R6", int'(thr_out[0 +: TW]), 594);
      apply(1, 0, 100, 100, 900, 7, 20, 0, 100, "R6");
      check_eq("R6", int'(thr_out[3*TW +: TW]), 592);

      // R5 drain stage 3 to zero, never negative
      for (int k = 0; k < 6; k++) apply(1, 0, 0, 0, 4000, 4, 255, 0, 100, "R5");
      check_eq("R5", int'(thr_out[3*TW +: TW]), 100);

      // R2 saturation at the top
      apply(0, 0, 0, 0, 0, 4, 0, 0, 4000, "R2");
      check_eq("R2", int'(thr_out[0 +: TW]), TMAX);

      // R5 clamp at the top: pump stage 1 toward the maximum
      for (int k = 0; k < 12; k++) apply(1, 1000, 0, 1000, 1000, 4, 255, 0, 0, "R5");
      check_eq("R5", int'(thr_out[TW +: TW]), AMAX);

      // R3 R4 R5 R6 R8 R9 random mix
      for (int k = 0; k < 3000; k++) begin
         int narrow = ($urandom % 4 == 0);
         int c [NS];
         for (int s = 0; s < NS; s++) c[s] = narrow ? int'($urandom % 4) : int'($urandom % 4096);
         apply(($urandom % 5) != 0, c[0], c[1], c[2], c[3], int'($urandom % 8),
               ($urandom % 3 == 0) ? 255 : int'($urandom % 32), int'($urandom % 6),
               int'($urandom % 4096), "R3");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule